// File: doc/BRIEF.md
# Cache Control Register with Invalidate Sequencing

This block is the single control word for a group of three caches: instruction, data and peripheral data. The same word also controls a predictive prefetch buffer, the flash access wait states, the enable for the cache performance counters and the enable for the corrected-single-bit-error interrupt. Software updates it through a plain write port with one byte enable per lane. The full word is always visible on a read port.

The core of the block turns events into invalidate requests, one per cache. The events are a write of 1 to a manual invalidate bit, a write that switches a cache off, and a flash programming event for a cache whose auto-coherency bit is set. Each request is a level that stays high until the matching cache acknowledges. The matching register bit reads as busy for the same span, and each cache finishes on its own schedule. The instruction-cache request also invalidates the prefetch buffer.

When the counter enable goes from 0 to 1, the block issues a one-cycle clear pulse to the performance counters.

Top module: `cache_ctl_reg`

## Requirements
- R1: After a synchronous reset the read word is 0x0700010F, no invalidate is requested, all three caches are enabled and `flash_ws` is 16.
- R2: A write changes only the fields in byte lanes whose `wr_be` bit is set. A write with no lane enabled changes nothing.
- R3: Reserved bits (mask 0xF888EE40) always read 0. Bit 8, the address wait state, always reads 1, and writes do not change either.
- R4: Writing 1 to bit 20+i (i=0 instruction, 1 data, 2 peripheral data) raises `inv_req[i]` and read bit 20+i on the next cycle. Writing 0 there has no effect.
- R5: A raised `inv_req[i]` stays high until `inv_ack[i]` is sampled high, and it is low on the following cycle. Each cache clears on its own. An acknowledge while idle is ignored.
- R6: A `prog_event` pulse starts an invalidate of cache i when auto-coherency bit 16+i is 1, and it does nothing to that cache when the bit is 0.
- R7: A write that changes enable bit 24+i from 1 to 0 starts an invalidate of cache i. A write of 0 to an enable that is already 0 does not.
- R8: `pfb_inv` is high exactly while the instruction-cache invalidate is outstanding.
- R9: A new trigger for a cache that is already busy is absorbed: the request stays high, and one acknowledge ends it.
- R10: A 0-to-1 change of bit 12 makes `perf_clr` high for exactly one cycle. Writing 1 while the bit is already 1 gives no pulse. `perf_en` follows bit 12.
- R11: `sec_irq` equals `sec_flag` AND bit 7.
- R12: Bits 5:4 accept code 00 (prefetch off) and 01 (prefetch for cacheable regions). A write of 10 or 11 leaves the field unchanged. `prefetch_en` is 1 only for code 01.
- R13: `flash_ws` equals 1 plus bits 3:0, for every value from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables, bit n covers bits 8n+7:8n |
| rd_data | output | 32 | Current register word |
| prog_event | input | 1 | One-cycle flash programming event |
| inv_ack | input | 3 | Per-cache invalidate completion |
| inv_req | output | 3 | Per-cache invalidate request, held until acknowledged |
| pfb_inv | output | 1 | Prefetch buffer invalidate |
| cache_en | output | 3 | Per-cache enable |
| perf_en | output | 1 | Performance counter enable |
| perf_clr | output | 1 | One-cycle counter clear |
| sec_flag | input | 1 | Corrected single-bit error flag |
| sec_irq | output | 1 | Gated error interrupt |
| prefetch_en | output | 1 | Predictive prefetch enable |
| flash_ws | output | 5 | Total flash wait states |

## Verification
The wait-state field is swept over all 16 values. All four prefetch codes are written, which separates accepted codes from rejected ones. Every combination of error flag and interrupt enable is applied. Invalidates are started through each of the three trigger paths (manual bit, enable falling, programming event with and without coherency) and acknowledged in staggered order. These patterns show whether caches clear independently, whether idle acknowledges are ignored and whether repeated triggers are absorbed. Writes with partial and empty byte enables, and a write of ones to every reserved bit, separate lane gating from field masking.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;

    localparam int NCACHE  = 3;
    localparam int WS_W    = 4;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int TWS_W   = WS_W + 1;

    // bit positions of each field in the control word
    localparam int EN_LSB    = 24;
    localparam int INV_LSB   = 20;
    localparam int COH_LSB   = 16;
    localparam int PERF_BIT  = 12;
    localparam int ADRWS_BIT = 8;
    localparam int SECEN_BIT = 7;
    localparam int PF_LSB    = 4;

    // byte lane holding each field
    localparam int LANE_EN   = EN_LSB / 8;
    localparam int LANE_INV  = INV_LSB / 8;
    localparam int LANE_COH  = COH_LSB / 8;
    localparam int LANE_PERF = PERF_BIT / 8;
    localparam int LANE_LOW  = 0;

    localparam logic ADR_WS = 1'b1;

    typedef enum logic [1:0] {
        PF_OFF       = 2'b00,
        PF_CACHEABLE = 2'b01
    } pf_mode_e;

    typedef struct packed {
        logic [NCACHE-1:0] en;
        logic [NCACHE-1:0] coh;
        logic              perf;
        logic              secen;
        pf_mode_e          pf;
        logic [WS_W-1:0]   ws;
    } ctl_fields_t;

    localparam ctl_fields_t FIELDS_RST = '{
        en:    {NCACHE{1'b1}},
        coh:   {NCACHE{1'b0}},
        perf:  1'b0,
        secen: 1'b0,
        pf:    PF_OFF,
        ws:    {WS_W{1'b1}}
    };

    function automatic logic pf_code_ok(input logic [1:0] code);
        return (code == 2'(PF_OFF)) || (code == 2'(PF_CACHEABLE));
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(input ctl_fields_t f,
                                                    input logic [NCACHE-1:0] busy);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_LSB  +: NCACHE] = f.en;
        w[INV_LSB +: NCACHE] = busy;
        w[COH_LSB +: NCACHE] = f.coh;
        w[PERF_BIT]          = f.perf;
        w[ADRWS_BIT]         = ADR_WS;
        w[SECEN_BIT]         = f.secen;
        w[PF_LSB +: 2]       = 2'(f.pf);
        w[0 +: WS_W]         = f.ws;
        return w;
    endfunction

endpackage

// File: rtl/ccr_fields.sv
module ccr_fields
    import cache_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output ctl_fields_t       fields,
    output logic [NCACHE-1:0] en_fall,
    output logic [NCACHE-1:0] inv_wr
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            fields <= FIELDS_RST;
        end else if (wr_en) begin
            if (wr_be[LANE_LOW]) begin
                fields.ws    <= wr_data[0 +: WS_W];
                fields.secen <= wr_data[SECEN_BIT];
                if (pf_code_ok(wr_data[PF_LSB +: 2]))
                    fields.pf <= pf_mode_e'(wr_data[PF_LSB +: 2]);
            end
            if (wr_be[LANE_PERF])
                fields.perf <= wr_data[PERF_BIT];
            if (wr_be[LANE_COH])
                fields.coh <= wr_data[COH_LSB +: NCACHE];
            if (wr_be[LANE_EN])
                fields.en <= wr_data[EN_LSB +: NCACHE];
        end
    end

    always_comb begin
        en_fall = {NCACHE{wr_en & wr_be[LANE_EN]}} & fields.en
                  & ~wr_data[EN_LSB +: NCACHE];
        inv_wr  = {NCACHE{wr_en & wr_be[LANE_INV]}} & wr_data[INV_LSB +: NCACHE];
    end

endmodule

// File: rtl/ccr_inval_seq.sv
module ccr_inval_seq (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic ack,
    output logic busy
);

    // idle: a trigger arms; busy: only the acknowledge ends it, so triggers merge
    always_ff @(posedge clk) begin
        if (rst)
            busy <= 1'b0;
        else if (busy)
            busy <= ~ack;
        else
            busy <= trig;
    end

endmodule

// File: rtl/ccr_edge_pulse.sv
module ccr_edge_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= 1'b0;
        else
            level_q <= level;
    end

    assign pulse = level & ~level_q;

endmodule

// File: rtl/cache_ctl_reg.sv
module cache_ctl_reg
    import cache_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output logic [DATA_W-1:0] rd_data,
    input  logic              prog_event,
    input  logic [NCACHE-1:0] inv_ack,
    output logic [NCACHE-1:0] inv_req,
    output logic              pfb_inv,
    output logic [NCACHE-1:0] cache_en,
    output logic              perf_en,
    output logic              perf_clr,
    input  logic              sec_flag,
    output logic              sec_irq,
    output logic              prefetch_en,
    output logic [TWS_W-1:0]  flash_ws
);

    localparam int ICACHE = 0;

    ctl_fields_t       fields;
    logic [NCACHE-1:0] en_fall;
    logic [NCACHE-1:0] inv_wr;
    logic [NCACHE-1:0] busy;

    ccr_fields u_fields (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .fields  (fields),
        .en_fall (en_fall),
        .inv_wr  (inv_wr)
    );

    for (genvar i = 0; i < NCACHE; i++) begin : g_cache
        logic trig;
        assign trig = inv_wr[i] | en_fall[i] | (prog_event & fields.coh[i]);

        ccr_inval_seq u_seq (
            .clk  (clk),
            .rst  (rst),
            .trig (trig),
            .ack  (inv_ack[i]),
            .busy (busy[i])
        );
    end

    ccr_edge_pulse u_perf_edge (
        .clk   (clk),
        .rst   (rst),
        .level (fields.perf),
        .pulse (perf_clr)
    );

    assign rd_data     = pack_word(fields, busy);
    assign inv_req     = busy;
    assign pfb_inv     = busy[ICACHE];
    assign cache_en    = fields.en;
    assign perf_en     = fields.perf;
    assign sec_irq     = sec_flag & fields.secen;
    assign prefetch_en = (fields.pf == PF_CACHEABLE);
    assign flash_ws    = {1'b0, fields.ws} + TWS_W'(ADR_WS);

endmodule

// File: rtl/cache_ctl_reg_chk.sv
module cache_ctl_reg_chk
    import cache_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [BE_W-1:0]   wr_be,
    input logic [DATA_W-1:0] rd_data,
    input logic              prog_event,
    input logic [NCACHE-1:0] inv_ack,
    input logic [NCACHE-1:0] inv_req,
    input logic              pfb_inv,
    input logic [NCACHE-1:0] cache_en,
    input logic              perf_clr,
    input logic              sec_flag,
    input logic              sec_irq,
    input logic [TWS_W-1:0]  flash_ws
);

    localparam logic [DATA_W-1:0] RSV_MASK = 32'hF888EE40;

    assert_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        ((rd_data & RSV_MASK) == '0) && rd_data[ADRWS_BIT]);

    assert_clr_single_R10: assert property (@(posedge clk) disable iff (rst)
        perf_clr |=> !perf_clr);

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
        sec_irq == (sec_flag & rd_data[SECEN_BIT]));

    assert_pf_code_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_data[PF_LSB + 1]);

    assert_ws_total_R13: assert property (@(posedge clk) disable iff (rst)
        flash_ws == ({1'b0, rd_data[WS_W-1:0]} + TWS_W'(1)));

    assert_pfb_follow_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pfb_inv) |-> $rose(inv_req[0]));

    for (genvar i = 0; i < NCACHE; i++) begin : g_chk
        assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (inv_req[i] && !inv_ack[i]) |=> inv_req[i]);

        assert_ack_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (inv_req[i] && inv_ack[i]) |=> !inv_req[i]);

        assert_w1s_R4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_be[LANE_INV] && wr_data[INV_LSB + i] && !inv_req[i])
            |=> inv_req[i]);

        assert_coh_R6: assert property (@(posedge clk) disable iff (rst)
            (prog_event && rd_data[COH_LSB + i] && !inv_req[i]) |=> inv_req[i]);

        assert_disable_R7: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_be[LANE_EN] && cache_en[i] && !wr_data[EN_LSB + i]
             && !inv_req[i]) |=> inv_req[i]);
    end

endmodule

bind cache_ctl_reg cache_ctl_reg_chk u_chk (.*);

// File: tb/test_cache_ctl_reg.sv
module test_cache_ctl_reg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [31:0] rd_data;
    logic        prog_event;
    logic [2:0]  inv_ack;
    logic [2:0]  inv_req;
    logic        pfb_inv;
    logic [2:0]  cache_en;
    logic        perf_en;
    logic        perf_clr;
    logic        sec_flag;
    logic        sec_irq;
    logic        prefetch_en;
    logic [4:0]  flash_ws;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_ctl_reg i_cache_ctl_reg (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .wr_be (wr_be), .rd_data (rd_data), .prog_event (prog_event),
        .inv_ack (inv_ack), .inv_req (inv_req), .pfb_inv (pfb_inv),
        .cache_en (cache_en), .perf_en (perf_en), .perf_clr (perf_clr),
        .sec_flag (sec_flag), .sec_irq (sec_irq), .prefetch_en (prefetch_en),
        .flash_ws (flash_ws)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0; wr_data = 32'h0;
    endtask

    task automatic ack(input logic [2:0] a);
        inv_ack = a;
        @(negedge clk);
        inv_ack = 3'b000;
    endtask

    task automatic prog();
        prog_event = 1'b1;
        @(negedge clk);
        prog_event = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; wr_be = '0;
        prog_event = 1'b0; inv_ack = '0; sec_flag = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 word", rd_data, 32'h0700010F);
        chk("R1 req", 32'(inv_req), 32'h0);
        chk("R1 en", 32'(cache_en), 32'h7);
        chk("R1 ws", 32'(flash_ws), 32'd16);

        // R13 sweep of the wait-state field
        for (int w = 0; w < 16; w++) begin
            wr(32'(w), 4'b0001);
            chk("R13 ws", 32'(flash_ws), 32'(w + 1));
        end

        // R12 prefetch codes
        wr(32'h10, 4'b0001);
        chk("R12 code01", {30'h0, rd_data[5:4]}, 32'h1);
        chk("R12 en", 32'(prefetch_en), 32'h1);
        wr(32'h20, 4'b0001);
        chk("R12 code10 kept", {30'h0, rd_data[5:4]}, 32'h1);
        wr(32'h30, 4'b0001);
        chk("R12 code11 kept", {30'h0, rd_data[5:4]}, 32'h1);
        wr(32'h00, 4'b0001);
        chk("R12 code00", {30'h0, rd_data[5:4]}, 32'h0);
        chk("R12 off", 32'(prefetch_en), 32'h0);

        // R11 interrupt gating
        for (int e = 0; e < 2; e++) begin
            for (int f = 0; f < 2; f++) begin
                wr(32'(e) << 7, 4'b0001);
                sec_flag = f[0];
                #1;
                chk("R11 irq", 32'(sec_irq), 32'(e & f));
            end
        end
        sec_flag = 1'b0;

        // R3 reserved bits and fixed bit 8
        wr(32'hFF88EE40, 4'b1111);
        chk("R3 word", rd_data, 32'h07000100);
        chk("R3 req", 32'(inv_req), 32'h0);

        // R2 byte lanes
        wr(32'hFFFFFF03, 4'b0001);
        chk("R2 lane0 only", rd_data, 32'h07000103);
        chk("R2 no inv", 32'(inv_req), 32'h0);
        wr(32'h00000000, 4'b0000);
        chk("R2 no lanes", rd_data, 32'h07000103);

        // R4 / R8 manual invalidate of instruction cache
        wr(32'h00100000, 4'b0100);
        chk("R4 req", 32'(inv_req), 32'h1);
        chk("R4 busy bit", {29'h0, rd_data[22:20]}, 32'h1);
        chk("R8 pfb", 32'(pfb_inv), 32'h1);
        wr(32'h00000000, 4'b0100);
        chk("R4 write0 no effect", 32'(inv_req), 32'h1);
        @(negedge clk);
        chk("R5 held", 32'(inv_req), 32'h1);
        ack(3'b001);
        chk("R5 cleared", 32'(inv_req), 32'h0);
        chk("R8 pfb off", 32'(pfb_inv), 32'h0);

        // R5 independent completion
        wr(32'h00600000, 4'b0100);
        chk("R4 two", 32'(inv_req), 32'h6);
        chk("R8 pfb idle", 32'(pfb_inv), 32'h0);
        ack(3'b010);
        chk("R5 data done", 32'(inv_req), 32'h4);
        ack(3'b100);
        chk("R5 periph done", 32'(inv_req), 32'h0);
        ack(3'b001);
        chk("R5 idle ack", 32'(inv_req), 32'h0);

        // R9 absorption
        wr(32'h00100000, 4'b0100);
        wr(32'h00100000, 4'b0100);
        chk("R9 still one", 32'(inv_req), 32'h1);
        ack(3'b001);
        chk("R9 single ack", 32'(inv_req), 32'h0);

        // R6 programming events
        wr(32'h00050000, 4'b0100);
        chk("R6 coh write", 32'(inv_req), 32'h0);
        prog();
        chk("R6 coh on", 32'(inv_req), 32'h5);
        ack(3'b101);
        chk("R6 done", 32'(inv_req), 32'h0);
        wr(32'h00000000, 4'b0100);
        prog();
        chk("R6 coh off", 32'(inv_req), 32'h0);

        // R7 disabling caches
        wr(32'h06000000, 4'b1000);
        chk("R7 en", 32'(cache_en), 32'h6);
        chk("R7 inv", 32'(inv_req), 32'h1);
        ack(3'b001);
        wr(32'h06000000, 4'b1000);
        chk("R7 already off", 32'(inv_req), 32'h0);
        wr(32'h07000000, 4'b1000);
        chk("R7 re-enable", 32'(inv_req), 32'h0);

        // R10 counter clear pulse
        wr(32'h00001000, 4'b0010);
        chk("R10 pulse", 32'(perf_clr), 32'h1);
        chk("R10 en", 32'(perf_en), 32'h1);
        @(negedge clk);
        chk("R10 one cycle", 32'(perf_clr), 32'h0);
        wr(32'h00001000, 4'b0010);
        chk("R10 no repeat", 32'(perf_clr), 32'h0);
        wr(32'h00000000, 4'b0010);
        chk("R10 off", 32'(perf_clr), 32'h0);
        wr(32'h00001000, 4'b0010);
        chk("R10 again", 32'(perf_clr), 32'h1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule